// File: doc/BRIEF.md
# Parallel NOR Flash Program and Erase Sequencer

This block is a bus master for an asynchronous parallel NOR flash. A client hands it one high-level request at a time: program one word, program two or four adjacent words in one page operation, erase a block, or suspend or resume an operation in progress. The sequencer turns the request into write cycles with the right command bytes. It then keeps reading the flash status register until the device reports ready, and translates the status error bits into a compact result code.

After every operation the flash is put back into array-read mode. When the status showed an error, or polling gave up, the status register is cleared before that. Requests that ask for a multi-word page at a badly aligned base address, and requests with an opcode the block does not know, are refused on the spot without touching the flash bus. The client sees a ready signal while the sequencer is idle and a one-cycle response pulse that carries the result.

Top module: `nor_prog_seq`

## Requirements
- R1: Out of reset the write and read strobes are both high (inactive), `req_ready` is 1 and `rsp_valid` is 0.
- R2: A word program (opcode 0) writes 40h and then the request's low data word, both at the base address.
- R3: A double-word program (opcode 1) writes 30h at the base address, then data word 0 at the base and data word 1 at base+1. If base bit 0 is 1, the result is ALIGN (code 4) and no bus cycle is made.
- R4: A quadruple-word program (opcode 2) writes 56h at the base address, then data words 0 to 3 at base to base+3. If base bits 1:0 are not 00, the result is ALIGN (code 4) and no bus cycle is made.
- R5: A block erase (opcode 3) writes 20h and then D0h, both at the block address.
- R6: A suspend (opcode 4) writes the single byte B0h, and a resume (opcode 5) writes the single byte D0h.
- R7: After the last command write the sequencer reads status with the read strobe low for one cycle and high for at least one cycle between reads. It makes no write until a read returns bit 7 set, and it makes exactly one read per busy status plus the final ready read.
- R8: The ready status is decoded with this priority. Bits 4 and 5 both set give SEQ_ERROR (3). Otherwise bit 1 gives PROTECTED (1). Otherwise bit 5 gives ERASE_FAIL (2). Otherwise bit 4 gives PROG_FAIL (6). Otherwise the result is OK (0).
- R9: A result of OK is followed by a single write of FFh. Any other result reached on the bus is followed by a write of 50h and then FFh. All of these writes go to the base address.
- R10: If POLL_LIMIT status reads in a row all show bit 7 clear, the result is TIMEOUT (5), followed by 50h and FFh.
- R11: An opcode of 6 or 7 gives SEQ_ERROR (3) with no bus cycle.
- R12: A request is taken only while `req_ready` is 1. Each accepted request yields exactly one one-cycle `rsp_valid` pulse. A request raised while busy causes no bus cycle and no response.
- R13: The two strobes are never low together. A write strobe lasts one cycle, and address and data hold for the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle; request taken when both are high |
| req_op | input | 3 | 0 word, 1 double, 2 quad, 3 erase, 4 suspend, 5 resume |
| req_addr | input | AW | Base word address or block address |
| req_data | input | 4*DW | Data words 0..3, word 0 in the low bits |
| rsp_valid | output | 1 | One-cycle result pulse |
| rsp_code | output | 3 | Result code, valid with rsp_valid |
| fl_addr | output | AW | Flash address |
| fl_wdata | output | DW | Flash write data |
| fl_rdata | input | DW | Flash read data (status during polling) |
| fl_we_n | output | 1 | Flash write strobe, active low |
| fl_oe_n | output | 1 | Flash read strobe, active low |

## Verification
The hardest case to reach is a client raising a request while an operation is still running on the bus, because the front end only misbehaves there if it leaks the new request into the running sequence. The bench keeps `req_valid` high for several cycles after acceptance with a different opcode. The scoreboard then flags any extra write or response. The timeout path needs a flash that never becomes ready, so the bench's flash model holds status bit 7 clear for more reads than the poll limit and counts the reads. The decode priority is reached by having the model return chosen combinations of error bits on the ready read.

// File: rtl/nor_prog_seq.sv
module nor_prog_seq #(
  parameter int AW = 21,
  parameter int DW = 16,
  parameter int POLL_LIMIT = 64,
  parameter logic [7:0] SUSPEND_CMD = 8'hB0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [2:0]      req_op,
  input  logic [AW-1:0]   req_addr,
  input  logic [4*DW-1:0] req_data,
  output logic            rsp_valid,
  output logic [2:0]      rsp_code,
  output logic [AW-1:0]   fl_addr,
  output logic [DW-1:0]   fl_wdata,
  input  logic [DW-1:0]   fl_rdata,
  output logic            fl_we_n,
  output logic            fl_oe_n
);

  localparam int PCW = $clog2(POLL_LIMIT + 1);

  localparam logic [2:0] OP_WORD = 3'd0, OP_DBL = 3'd1, OP_QUAD = 3'd2,
                         OP_ERASE = 3'd3, OP_SUSP = 3'd4, OP_RESUME = 3'd5;

  localparam logic [2:0] RC_OK = 3'd0, RC_PROT = 3'd1, RC_EFAIL = 3'd2,
                         RC_SEQ = 3'd3, RC_ALIGN = 3'd4, RC_TMO = 3'd5,
                         RC_PFAIL = 3'd6;

  typedef enum logic [2:0] {S_IDLE, S_WLO, S_WHI, S_RLO, S_RHI, S_DONE} st_t;
  typedef enum logic [1:0] {P_CMD, P_CLR, P_RA} ph_t;

  st_t             st;
  ph_t             ph;
  logic [2:0]      op;
  logic [AW-1:0]   base;
  logic [4*DW-1:0] dat;
  logic [2:0]      step;
  logic [PCW-1:0]  pcnt;
  logic [2:0]      code;

  logic [2:0]      last_step;
  logic [1:0]      widx;
  logic [1:0]      wr_off;
  logic [7:0]      cmd_byte;
  logic [2:0]      dec_code;
  logic            align_bad, op_bad;
  logic            unused_bits;

  assign req_ready = (st == S_IDLE);
  assign rsp_valid = (st == S_DONE);
  assign rsp_code  = code;
  assign fl_we_n   = (st != S_WLO);
  assign fl_oe_n   = (st != S_RLO);
  assign widx      = 2'(step - 3'd1);
  assign unused_bits = ^{fl_rdata[DW-1:8], fl_rdata[6], fl_rdata[3:2], fl_rdata[0]};

  assign align_bad = (req_op == OP_DBL  && req_addr[0]) ||
                     (req_op == OP_QUAD && req_addr[1:0] != 2'b00);
  assign op_bad    = (req_op > OP_RESUME);

  always_comb begin
    case (op)
      OP_WORD:  last_step = 3'd1;
      OP_DBL:   last_step = 3'd2;
      OP_QUAD:  last_step = 3'd4;
      OP_ERASE: last_step = 3'd1;
      default:  last_step = 3'd0;
    endcase
  end

  always_comb begin
    case (op)
      OP_WORD:  cmd_byte = 8'h40;
      OP_DBL:   cmd_byte = 8'h30;
      OP_QUAD:  cmd_byte = 8'h56;
      OP_ERASE: cmd_byte = 8'h20;
      OP_SUSP:  cmd_byte = SUSPEND_CMD;
      default:  cmd_byte = 8'hD0;
    endcase
  end

  always_comb begin
    wr_off   = 2'd0;
    fl_wdata = DW'(8'hFF);
    case (ph)
      P_CLR: fl_wdata = DW'(8'h50);
      P_RA:  fl_wdata = DW'(8'hFF);
      default: begin
        if (step == 3'd0) begin
          fl_wdata = DW'(cmd_byte);
        end else if (op == OP_ERASE) begin
          fl_wdata = DW'(8'hD0);
        end else begin
          fl_wdata = dat[widx*DW +: DW];
          wr_off   = widx;
        end
      end
    endcase
  end

  assign fl_addr = (st == S_WLO || st == S_WHI) ? base + AW'(wr_off) : base;

  always_comb begin
    if (fl_rdata[4] && fl_rdata[5]) dec_code = RC_SEQ;
    else if (fl_rdata[1])           dec_code = RC_PROT;
    else if (fl_rdata[5])           dec_code = RC_EFAIL;
    else if (fl_rdata[4])           dec_code = RC_PFAIL;
    else                            dec_code = RC_OK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      ph   <= P_CMD;
      op   <= OP_WORD;
      base <= '0;
      dat  <= '0;
      step <= '0;
      pcnt <= '0;
      code <= RC_OK;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          op   <= req_op;
          base <= req_addr;
          dat  <= req_data;
          step <= '0;
          ph   <= P_CMD;
          pcnt <= '0;
          if (op_bad) begin
            code <= RC_SEQ;
            st   <= S_DONE;
          end else if (align_bad) begin
            code <= RC_ALIGN;
            st   <= S_DONE;
          end else begin
            st <= S_WLO;
          end
        end
        S_WLO: st <= S_WHI;
        S_WHI: begin
          case (ph)
            P_CMD: if (step == last_step) begin
              pcnt <= '0;
              st   <= S_RLO;
            end else begin
              step <= step + 3'd1;
              st   <= S_WLO;
            end
            P_CLR: begin
              ph <= P_RA;
              st <= S_WLO;
            end
            default: st <= S_DONE;
          endcase
        end
        S_RLO: begin
          if (fl_rdata[7]) begin
            code <= dec_code;
            ph   <= (dec_code == RC_OK) ? P_RA : P_CLR;
            st   <= S_WLO;
          end else if (pcnt == PCW'(POLL_LIMIT - 1)) begin
            code <= RC_TMO;
            ph   <= P_CLR;
            st   <= S_WLO;
          end else begin
            pcnt <= pcnt + 1'b1;
            st   <= S_RHI;
          end
        end
        S_RHI:   st <= S_RLO;
        S_DONE:  st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

module nor_prog_seq_chk #(
  parameter int AW = 21,
  parameter int DW = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic [2:0]      req_op,
  input logic [AW-1:0]   req_addr,
  input logic            rsp_valid,
  input logic [2:0]      rsp_code,
  input logic [AW-1:0]   fl_addr,
  input logic [DW-1:0]   fl_wdata,
  input logic [DW-1:0]   fl_rdata,
  input logic            fl_we_n,
  input logic            fl_oe_n
);

  p_strobe_excl_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !(!fl_we_n && !fl_oe_n));

  p_we_pulse_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !fl_we_n |=> fl_we_n && $stable(fl_addr) && $stable(fl_wdata));

  p_oe_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !fl_oe_n |=> fl_oe_n);

  p_ready_to_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!fl_oe_n && fl_rdata[7]) |=> !fl_we_n);

  p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> fl_we_n && fl_oe_n);

  p_rsp_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid && req_ready);

  p_rsp_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

  p_align_dbl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && req_valid && req_op == 3'd1 && req_addr[0])
      |=> rsp_valid && rsp_code == 3'd4);

  p_align_quad_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && req_valid && req_op == 3'd2 && req_addr[1:0] != 2'b00)
      |=> rsp_valid && rsp_code == 3'd4);

  p_bad_op_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && req_valid && req_op > 3'd5) |=> rsp_valid && rsp_code == 3'd3);

endmodule

bind nor_prog_seq nor_prog_seq_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_op(req_op), .req_addr(req_addr), .rsp_valid(rsp_valid),
  .rsp_code(rsp_code), .fl_addr(fl_addr), .fl_wdata(fl_wdata),
  .fl_rdata(fl_rdata), .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n)
);

// File: tb/nor_prog_seq_test.sv
module nor_prog_seq_test;

  localparam int AW = 21;
  localparam int DW = 16;
  localparam int LIM = 64;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            req_valid = 1'b0;
  logic            req_ready;
  logic [2:0]      req_op = '0;
  logic [AW-1:0]   req_addr = '0;
  logic [4*DW-1:0] req_data = '0;
  logic            rsp_valid;
  logic [2:0]      rsp_code;
  logic [AW-1:0]   fl_addr;
  logic [DW-1:0]   fl_wdata;
  logic [DW-1:0]   fl_rdata;
  logic            fl_we_n, fl_oe_n;

  always #5 clk = ~clk;

  nor_prog_seq #(.AW(AW), .DW(DW), .POLL_LIMIT(LIM)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_data(req_data),
    .rsp_valid(rsp_valid), .rsp_code(rsp_code), .fl_addr(fl_addr),
    .fl_wdata(fl_wdata), .fl_rdata(fl_rdata), .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n)
  );

  int        reads_seen = 0;
  int        rd_base = 0;
  int        busy_n = 0;
  logic [7:0] err_bits = 8'h00;

  always @(posedge clk) if (rst_n && !fl_oe_n) reads_seen <= reads_seen + 1;
  assign fl_rdata = ((reads_seen - rd_base) < busy_n) ? 16'h0000 : {8'h00, 8'h80 | err_bits};

  logic [AW-1:0] ea[$];
  logic [DW-1:0] ed[$];
  string         et[$];
  logic [2:0]    ec[$];
  string         ect[$];

  int checks = 0, errors = 0;
  int mchecks = 0, merrors = 0;
  int rsp_cnt = 0;

  always @(negedge clk) begin
    if (rst_n && !fl_we_n) begin
      mchecks++;
      if (ea.size() == 0) begin
        merrors++;
        $display("FAIL R12 unexpected write: actual %h@%h expected none", fl_wdata, fl_addr);
      end else begin
        logic [AW-1:0] a;
        logic [DW-1:0] d;
        string t;
        a = ea.pop_front(); d = ed.pop_front(); t = et.pop_front();
        if (a !== fl_addr || d !== fl_wdata) begin
          merrors++;
          $display("FAIL %s write: actual %h@%h expected %h@%h", t, fl_wdata, fl_addr, d, a);
        end
      end
    end
    if (rst_n && rsp_valid) begin
      rsp_cnt++;
      mchecks++;
      if (ec.size() == 0) begin
        merrors++;
        $display("FAIL R12 unexpected response: actual %0d expected none", rsp_code);
      end else begin
        logic [2:0] c;
        string t;
        c = ec.pop_front(); t = ect.pop_front();
        if (c !== rsp_code) begin
          merrors++;
          $display("FAIL %s result: actual %0d expected %0d", t, rsp_code, c);
        end
      end
    end
  end

  task automatic chk(bit ok, string msg, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", msg, act, exp);
    end
  endtask

  task automatic push_w(logic [AW-1:0] a, logic [7:0] d, string t);
    ea.push_back(a); ed.push_back(DW'(d)); et.push_back(t);
  endtask

  task automatic run_op(input logic [2:0] op, input logic [AW-1:0] a,
                        input logic [4*DW-1:0] d, input int busy, input logic [7:0] err,
                        input logic [2:0] exp_code, input int exp_reads,
                        input bit poke, input string t);
    int start;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    busy_n = busy; err_bits = err; rd_base = reads_seen;
    if (exp_code != 3'd4 && op <= 3'd5) begin
      case (op)
        3'd0: begin push_w(a, 8'h40, t); ea.push_back(a); ed.push_back(d[15:0]); et.push_back(t); end
        3'd1: begin
          push_w(a, 8'h30, t);
          for (int i = 0; i < 2; i++) begin ea.push_back(a + AW'(i)); ed.push_back(d[i*DW +: DW]); et.push_back(t); end
        end
        3'd2: begin
          push_w(a, 8'h56, t);
          for (int i = 0; i < 4; i++) begin ea.push_back(a + AW'(i)); ed.push_back(d[i*DW +: DW]); et.push_back(t); end
        end
        3'd3: begin push_w(a, 8'h20, t); push_w(a, 8'hD0, t); end
        3'd4: push_w(a, 8'hB0, t);
        default: push_w(a, 8'hD0, t);
      endcase
      if (exp_code != 3'd0) push_w(a, 8'h50, "R9 clear");
      push_w(a, 8'hFF, "R9 read-array");
    end
    ec.push_back(exp_code); ect.push_back(t);
    start = rsp_cnt;
    req_op = op; req_addr = a; req_data = d; req_valid = 1'b1;
    @(negedge clk);
    if (poke) begin
      req_op = 3'd3; req_addr = a + 21'h40;
      repeat (3) @(negedge clk);
    end
    req_valid = 1'b0;
    while (rsp_cnt == start) @(negedge clk);
    @(negedge clk);
    chk(ea.size() == 0, {t, " pending writes"}, ea.size(), 0);
    if (exp_reads >= 0)
      chk(reads_seen - rd_base == exp_reads, {t, " R7 status reads"}, reads_seen - rd_base, exp_reads);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks + mchecks + 1, errors + merrors + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(fl_we_n === 1'b1, "R1 we_n", fl_we_n, 1);
    chk(fl_oe_n === 1'b1, "R1 oe_n", fl_oe_n, 1);
    chk(req_ready === 1'b1, "R1 req_ready", req_ready, 1);
    chk(rsp_valid === 1'b0, "R1 rsp_valid", rsp_valid, 0);
    rst_n = 1'b1;

    run_op(3'd0, 21'h12345, 64'h0000_0000_0000_BEEF, 3, 8'h00, 3'd0, 4, 0, "R2 word");
    run_op(3'd1, 21'h00100, 64'h0000_0000_2222_1111, 1, 8'h00, 3'd0, 2, 0, "R3 double");
    run_op(3'd1, 21'h00101, 64'h0000_0000_2222_1111, 0, 8'h00, 3'd4, 0, 0, "R3 double misaligned");
    run_op(3'd2, 21'h00200, 64'h4444_3333_2222_1111, 0, 8'h00, 3'd0, 1, 0, "R4 quad");
    run_op(3'd2, 21'h00202, 64'h4444_3333_2222_1111, 0, 8'h00, 3'd4, 0, 0, "R4 quad misaligned");
    run_op(3'd3, 21'h1F0000, 64'h0, 5, 8'h20, 3'd2, 6, 0, "R5 erase fail R8");
    run_op(3'd0, 21'h00010, 64'h0000_0000_0000_5A5A, 0, 8'h02, 3'd1, 1, 0, "R8 protected");
    run_op(3'd0, 21'h00011, 64'h0000_0000_0000_A5A5, 0, 8'h30, 3'd3, 1, 0, "R8 seq error");
    run_op(3'd0, 21'h00012, 64'h0000_0000_0000_0F0F, 2, 8'h10, 3'd6, 3, 0, "R8 prog fail");
    run_op(3'd3, 21'h008000, 64'h0, 0, 8'h22, 3'd1, 1, 0, "R8 protect over erase");
    run_op(3'd4, 21'h00000, 64'h0, 2, 8'h00, 3'd0, 3, 0, "R6 suspend");
    run_op(3'd5, 21'h00000, 64'h0, 0, 8'h00, 3'd0, 1, 0, "R6 resume");
    run_op(3'd0, 21'h00020, 64'h0000_0000_0000_1234, 1000, 8'h00, 3'd5, LIM, 0, "R10 timeout");
    run_op(3'd7, 21'h00030, 64'h0, 0, 8'h00, 3'd3, 0, 0, "R11 bad opcode");
    run_op(3'd6, 21'h00030, 64'h0, 0, 8'h00, 3'd3, 0, 0, "R11 bad opcode 6");
    run_op(3'd0, 21'h00040, 64'h0000_0000_0000_CAFE, 4, 8'h00, 3'd0, 5, 1, "R12 busy request");
    repeat (5) @(negedge clk);
    chk(ec.size() == 0, "R12 pending responses", ec.size(), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks + mchecks, errors + merrors);
    $finish;
  end

endmodule